// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Controller

This block controls a port of general-purpose pins through a word-wide register bus. Every per-pin control has three words: an enable word where a 1 sets the matching bit, a disable word where a 1 clears it, and a readable status word. Bits written as 0 are left alone, so software can change any group of pins without reading first. The controlled functions are: pin ownership (the port itself or an on-chip peripheral), output-driver enable, input glitch filtering, interrupt masking, open-drain operation, pull-up enable, and a mask that limits whole-port output writes.

The output latch has a set word and a clear word that take effect on the pad one clock after the write. It can also be written in full at its status offset. That write passes through a staging register, changes only the bits the write mask allows, and reaches the pad two clocks after the write. Pad inputs pass through a two-flop synchronizer and an optional per-pin filter, which gives the accepted pin level. A change of the accepted level on an unmasked pin latches a bit in an interrupt status word, which clears when read. The interrupt line is high while any status bit is set.

The bus is a simple single-cycle strobe interface. A read returns data in the cycle after the strobe. Writes take effect at the strobe edge.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, status at 0x08 reads all ones (every pin owned by the port), output enable status (0x18), output latch (0x38), interrupt mask (0x48), filter (0x28), open-drain (0x58) and pull-up (0x68) status read 0, and pad_oe, pad_pullup and irq are 0.
- R2: For each control group with base B (own 0x00, output enable 0x10, filter 0x20, interrupt mask 0x40, open drain 0x50, pull-up 0x60, write mask 0xA0), a 1 written to B sets the bit read at B+8, a 1 written to B+4 clears it, and bits written as 0 keep their value.
- R3: A write to 0x30 sets and a write to 0x34 clears output latch bits. The latch reads back at 0x38 and appears on pad_out one clock after the write edge, for port-owned pins that are not open drain.
- R4: A write to 0x38 updates only latch bits whose write-mask bit (status 0x A8) is 1, and reaches pad_out two clocks after the write edge.
- R5: A read of 0x3C returns the accepted input level of every pin, independent of the output latch and output enables.
- R6: With the filter bit of a pin set, an input change is accepted only after it has been stable for two synchronized samples, so a one-clock pulse is ignored. With the filter off, the same pulse is accepted.
- R7: A change of accepted level on a pin whose interrupt mask bit is 1 sets its bit at 0x4C, a pin with mask bit 0 sets nothing, and irq is 1 while any bit at 0x4C is set.
- R8: A read of 0x4C returns the pending bits and clears them, so an immediate second read returns 0 and irq falls.
- R9: For a port-owned pin with its open-drain bit set, pad_out is 0, and pad_oe is 1 only when the output enable is 1 and the latch bit is 0.
- R10: For a pin whose ownership bit is 0, pad_out and pad_oe follow periph_out and periph_oe with one clock of delay.
- R11: Reads of write-only offsets (for example 0x00, 0x30) and reserved offsets (for example 0x0C, 0xFC) return 0.
- R12: pad_pullup equals the pull-up status word (0x68) from the edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | N_PINS | Write data |
| bus_rdata | output | N_PINS | Read data, valid the cycle after a read strobe |
| pad_in | input | N_PINS | Raw pad input levels |
| periph_out | input | N_PINS | Output value from the peripheral for pins it owns |
| periph_oe | input | N_PINS | Driver enable from the peripheral for pins it owns |
| pad_out | output | N_PINS | Pad output value |
| pad_oe | output | N_PINS | Pad driver enable |
| pad_pullup | output | N_PINS | Pull-up enable per pin |
| irq | output | 1 | Pending input-change interrupt |

## Verification
A wrong control status bit shows at the next read of its status word and, for output controls, on pad_out or pad_oe within one clock. A corrupted staging register shows as wrong or unmasked pad bits exactly two clocks after a whole-port write. Errors in the synchronizer or filter show as a wrong level at 0x3C a few clocks after a pad change, or as a single-clock pulse that wrongly raises irq. An interrupt status that fails to clear shows on the second back-to-back read of 0x4C and as irq staying high.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  // control groups that share the enable / disable / status layout
  localparam int NCTL    = 7;
  localparam int C_OWN   = 0;
  localparam int C_OE    = 1;
  localparam int C_FILT  = 2;
  localparam int C_IMR   = 3;
  localparam int C_OD    = 4;
  localparam int C_PU    = 5;
  localparam int C_WMASK = 6;

  localparam logic [7:0] CTL_BASE [NCTL] = '{8'h00, 8'h10, 8'h20, 8'h40, 8'h50, 8'h60, 8'hA0};

  localparam logic [7:0] OFF_DIS  = 8'h04;
  localparam logic [7:0] OFF_STAT = 8'h08;

  // output latch and input words
  localparam logic [7:0] OFF_SET  = 8'h30;
  localparam logic [7:0] OFF_CLR  = 8'h34;
  localparam logic [7:0] OFF_ODAT = 8'h38;
  localparam logic [7:0] OFF_LVL  = 8'h3C;
  localparam logic [7:0] OFF_ISR  = 8'h4C;
endpackage

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
  parameter int          W       = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= RST_VAL;
    else if (set_we) q <= q | wdata;
    else if (clr_we) q <= q & ~wdata;
  end

  // R2: a zero write leaves the status word alone
  assert_zero_write_R2: assert property (@(posedge clk) disable iff (rst)
    ((set_we || clr_we) && wdata == '0) |=> $stable(q));
  // R2: written ones are set by the enable word
  assert_set_bits_R2: assert property (@(posedge clk) disable iff (rst)
    (set_we && !clr_we) |=> ((q & $past(wdata)) == $past(wdata)));
  // R2: written ones are cleared by the disable word
  assert_clr_bits_R2: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !set_we) |=> ((q & $past(wdata)) == '0));
endmodule

// File: rtl/gpio_in_path.sv
module gpio_in_path #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pad_in,
  input  logic [W-1:0] filt_en,
  output logic [W-1:0] lvl,
  output logic [W-1:0] chg
);
  logic [W-1:0] sync1, sync2, hist;
  logic [W-1:0] accept, lvl_n;

  always_comb begin
    accept = ~filt_en | ~(sync2 ^ hist);
    lvl_n  = (accept & sync2) | (~accept & lvl);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= '0;
      sync2 <= '0;
      hist  <= '0;
      lvl   <= '0;
      chg   <= '0;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
      hist  <= sync2;
      lvl   <= lvl_n;
      chg   <= lvl_n ^ lvl;
    end
  end

  // R6: a filtered pin never moves while its two latest samples disagree
  assert_filter_hold_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((lvl ^ $past(lvl)) & $past(filt_en & (sync2 ^ hist))) == '0));
  // R7: the change pulse marks exactly the level moves of the previous edge
  assert_chg_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($past(chg ^ lvl) == ($past(chg) ^ $past(lvl))) && (chg == (lvl ^ $past(lvl))));
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] own,
  input  logic [W-1:0] oe,
  input  logic [W-1:0] od,
  input  logic [W-1:0] latch,
  input  logic [W-1:0] periph_out,
  input  logic [W-1:0] periph_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  logic [W-1:0] g_out, g_oe;

  always_comb begin
    g_out = latch & ~od;
    g_oe  = oe & ~(od & latch);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
    end else begin
      pad_out <= (own & g_out) | (~own & periph_out);
      pad_oe  <= (own & g_oe)  | (~own & periph_oe);
    end
  end

  // R9: an open-drain pin owned by the port never drives high
  assert_od_low_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_out & $past(own & od)) == '0));
  // R10: peripheral-owned pins follow the peripheral one clock later
  assert_periph_follow_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((pad_oe ^ $past(periph_oe)) & ~$past(own)) == '0));
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int N_PINS = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_PINS-1:0] bus_wdata,
  output logic [N_PINS-1:0] bus_rdata,
  input  logic [N_PINS-1:0] pad_in,
  input  logic [N_PINS-1:0] periph_out,
  input  logic [N_PINS-1:0] periph_oe,
  output logic [N_PINS-1:0] pad_out,
  output logic [N_PINS-1:0] pad_oe,
  output logic [N_PINS-1:0] pad_pullup,
  output logic              irq
);
  localparam logic [N_PINS-1:0] ALL_ONE = '1;

  logic wr, rd;
  assign wr = bus_valid & bus_write;
  assign rd = bus_valid & ~bus_write;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    return a == ADDR_W'(off);
  endfunction

  // ---------------- control groups ----------------
  logic [N_PINS-1:0] ctl_q [NCTL];

  for (genvar i = 0; i < NCTL; i++) begin : g_ctl
    localparam logic [N_PINS-1:0] RV = (i == C_OWN) ? ALL_ONE : '0;
    logic s_we, c_we;
    assign s_we = wr && hit(bus_addr, CTL_BASE[i]);
    assign c_we = wr && hit(bus_addr, CTL_BASE[i] + OFF_DIS);
    gpio_setclr_reg #(.W(N_PINS), .RST_VAL(RV)) u_reg (
      .clk(clk), .rst(rst), .set_we(s_we), .clr_we(c_we),
      .wdata(bus_wdata), .q(ctl_q[i])
    );
  end

  // ---------------- output latch ----------------
  logic [N_PINS-1:0] latch, latch_n;
  logic [N_PINS-1:0] stage_d, stage_m;
  logic              stage_v;
  logic              set_we, clr_we, port_we;

  assign set_we  = wr && hit(bus_addr, OFF_SET);
  assign clr_we  = wr && hit(bus_addr, OFF_CLR);
  assign port_we = wr && hit(bus_addr, OFF_ODAT);

  always_comb begin
    latch_n = latch;
    if (stage_v) latch_n = (latch_n & ~stage_m) | (stage_d & stage_m);
    if (set_we)  latch_n = latch_n | bus_wdata;
    if (clr_we)  latch_n = latch_n & ~bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch   <= '0;
      stage_v <= 1'b0;
      stage_d <= '0;
      stage_m <= '0;
    end else begin
      latch   <= latch_n;
      stage_v <= port_we;
      stage_d <= bus_wdata;
      stage_m <= ctl_q[C_WMASK];
    end
  end

  // ---------------- input path and interrupts ----------------
  logic [N_PINS-1:0] lvl, chg, isr, isr_n;
  logic              rd_isr;

  gpio_in_path #(.W(N_PINS)) u_in (
    .clk(clk), .rst(rst), .pad_in(pad_in), .filt_en(ctl_q[C_FILT]),
    .lvl(lvl), .chg(chg)
  );

  assign rd_isr = rd && hit(bus_addr, OFF_ISR);
  assign isr_n  = (rd_isr ? '0 : isr) | (chg & ctl_q[C_IMR]);

  always_ff @(posedge clk) begin
    if (rst) begin
      isr <= '0;
      irq <= 1'b0;
    end else begin
      isr <= isr_n;
      irq <= |isr_n;
    end
  end

  // ---------------- pad drive ----------------
  gpio_pad_drive #(.W(N_PINS)) u_pad (
    .clk(clk), .rst(rst),
    .own(ctl_q[C_OWN]), .oe(ctl_q[C_OE]), .od(ctl_q[C_OD]), .latch(latch),
    .periph_out(periph_out), .periph_oe(periph_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  assign pad_pullup = ctl_q[C_PU];

  // ---------------- read mux ----------------
  logic [N_PINS-1:0] rmux;

  always_comb begin
    rmux = '0;
    for (int i = 0; i < NCTL; i++)
      if (hit(bus_addr, CTL_BASE[i] + OFF_STAT)) rmux = ctl_q[i];
    if (hit(bus_addr, OFF_ODAT)) rmux = latch;
    if (hit(bus_addr, OFF_LVL))  rmux = lvl;
    if (hit(bus_addr, OFF_ISR))  rmux = isr;
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (rd) bus_rdata <= rmux;
    else         bus_rdata <= '0;
  end

  // R3: port-owned push-pull pins show the latch one clock later
  assert_pad_latch_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((pad_out ^ $past(latch)) & $past(ctl_q[C_OWN] & ~ctl_q[C_OD])) == '0));
  // R4: a staged whole-port write leaves unmasked latch bits alone
  assert_port_mask_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(stage_v) && !$past(set_we || clr_we)) |->
      (((latch ^ $past(latch)) & ~$past(stage_m)) == '0));
  // R7: new pending bits only appear on unmasked pins
  assert_isr_masked_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((isr & ~$past(isr)) & ~$past(ctl_q[C_IMR])) == '0));
  // R7: the interrupt line tracks the pending word
  assert_irq_level_R7: assert property (@(posedge clk) disable iff (rst)
    irq == (isr != '0));
  // R8: a read of the pending word keeps only freshly arrived bits
  assert_isr_clear_R8: assert property (@(posedge clk) disable iff (rst)
    rd_isr |=> ((isr & ~$past(chg)) == '0));
endmodule

// File: tb/gpio_port_ctrl_test.sv
`timescale 1ns/1ps
module gpio_port_ctrl_test;
  localparam int N = 32;
  localparam int A = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_valid = 1'b0, bus_write = 1'b0;
  logic [A-1:0] bus_addr = '0;
  logic [N-1:0] bus_wdata = '0, bus_rdata;
  logic [N-1:0] pad_in = '0, periph_out = '0, periph_oe = '0;
  logic [N-1:0] pad_out, pad_oe, pad_pullup;
  logic         irq;

  always #10 clk = ~clk;

  gpio_port_ctrl #(.N_PINS(N), .ADDR_W(A)) uut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .periph_out(periph_out), .periph_oe(periph_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pullup(pad_pullup), .irq(irq)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // scoreboard queues: expected read value, compare mask, requirement tag
  logic [N-1:0] exp_q[$];
  logic [N-1:0] msk_q[$];
  string        tag_q[$];
  logic         rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= bus_valid & ~bus_write;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard: read data with no expected item");
      end else begin
        logic [N-1:0] e, m;
        string t;
        e = exp_q.pop_front(); m = msk_q.pop_front(); t = tag_q.pop_front();
        total++;
        if ((bus_rdata & m) !== (e & m)) begin
          bad++;
          $display("FAIL %s: read got %h expected %h (mask %h)", t, bus_rdata & m, e & m, m);
        end
      end
    end
  end

  task automatic wr(input logic [A-1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [A-1:0] a, input logic [N-1:0] e,
                    input logic [N-1:0] m, input string t);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    exp_q.push_back(e); msk_q.push_back(m); tag_q.push_back(t);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic chk(input logic [N-1:0] act, input logic [N-1:0] e, input string t);
    total++;
    if (act !== e) begin
      bad++;
      $display("FAIL %s: got %h expected %h", t, act, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not end, got hung expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(pad_oe, '0, "R1 pad_oe");
    chk(pad_pullup, '0, "R1 pad_pullup");
    chk({31'd0, irq}, '0, "R1 irq");
    rd(8'h08, 32'hFFFF_FFFF, '1, "R1 own status");
    rd(8'h18, '0, '1, "R1 oe status");
    rd(8'h28, '0, '1, "R1 filter status");
    rd(8'h38, '0, '1, "R1 latch");
    rd(8'h48, '0, '1, "R1 int mask");
    rd(8'h58, '0, '1, "R1 open drain");
    rd(8'h68, '0, '1, "R1 pull-up");

    // R2 write-one set / clear, zero writes ignored
    wr(8'h10, 32'h0000_00F0);
    rd(8'h18, 32'h0000_00F0, '1, "R2 oe set");
    wr(8'h14, 32'h0000_0030);
    rd(8'h18, 32'h0000_00C0, '1, "R2 oe clear");
    wr(8'h14, 32'h0);
    wr(8'h10, 32'h0);
    rd(8'h18, 32'h0000_00C0, '1, "R2 zero writes");

    // R3 set / clear latency of one clock
    wr(8'h30, 32'h0000_0080);
    chk(pad_out, '0, "R3 pad before latency");
    @(negedge clk);
    chk(pad_out, 32'h0000_0080, "R3 pad after set");
    rd(8'h38, 32'h0000_0080, '1, "R3 latch readback");
    wr(8'h34, 32'h0000_0080);
    chk(pad_out, 32'h0000_0080, "R3 pad before clear latency");
    @(negedge clk);
    chk(pad_out, '0, "R3 pad after clear");

    // R4 masked whole-port write with two-clock latency
    wr(8'hA0, 32'h0000_FF00);
    rd(8'hA8, 32'h0000_FF00, '1, "R2 write mask status");
    wr(8'h38, 32'hFFFF_FFFF);
    chk(pad_out, '0, "R4 pad one edge");
    @(negedge clk);
    chk(pad_out, '0, "R4 pad two edges");
    @(negedge clk);
    chk(pad_out, 32'h0000_FF00, "R4 pad after commit");
    rd(8'h38, 32'h0000_FF00, '1, "R4 latch masked");
    wr(8'h34, 32'h0000_FF00);

    // R5 pin level independent of output state
    pad_in = 32'h00FF_0000;
    idle(5);
    rd(8'h3C, 32'h00FF_0000, '1, "R5 pin level");
    pad_in = '0;
    idle(5);
    rd(8'h3C, '0, '1, "R5 pin level low");

    // R9 open drain
    wr(8'h50, 32'h20); wr(8'h10, 32'h20); wr(8'h30, 32'h20);
    idle(2);
    chk(pad_oe & 32'h20, '0, "R9 od released for 1");
    chk(pad_out & 32'h20, '0, "R9 od out low");
    wr(8'h34, 32'h20);
    idle(1);
    chk(pad_oe & 32'h20, 32'h20, "R9 od drives for 0");
    chk(pad_out & 32'h20, '0, "R9 od out low when driving");

    // R10 peripheral ownership
    periph_out = 32'h40; periph_oe = 32'h40;
    wr(8'h04, 32'h40);
    idle(2);
    chk(pad_out & 32'h40, 32'h40, "R10 periph out");
    chk(pad_oe & 32'h40, 32'h40, "R10 periph oe");
    rd(8'h08, ~32'h40, '1, "R10 own status");

    // R12 pull-up
    wr(8'h60, 32'h4);
    chk(pad_pullup, 32'h4, "R12 pull-up on");
    wr(8'h64, 32'h4);
    chk(pad_pullup, '0, "R12 pull-up off");

    // R11 write-only and reserved reads
    rd(8'h00, '0, '1, "R11 enable word");
    rd(8'h30, '0, '1, "R11 set word");
    rd(8'h0C, '0, '1, "R11 reserved 0C");
    rd(8'hFC, '0, '1, "R11 reserved FC");

    // R7 / R8 interrupts and clear on read
    wr(8'h40, 32'h8);
    rd(8'h48, 32'h8, '1, "R2 int mask status");
    rd(8'h4C, '0, '0, "R8 flush");
    pad_in = 32'h18;
    idle(6);
    chk({31'd0, irq}, 32'd1, "R7 irq raised");
    rd(8'h4C, 32'h8, '1, "R7 unmasked only");
    chk({31'd0, irq}, '0, "R8 irq after read");
    rd(8'h4C, '0, '1, "R8 cleared");

    // R6 filter rejects a one-clock pulse, unfiltered pin accepts it
    wr(8'h20, 32'h100);
    wr(8'h40, 32'h300);
    rd(8'h4C, '0, '0, "R6 flush");
    @(negedge clk); pad_in[8] = 1'b1;
    @(negedge clk); pad_in[8] = 1'b0;
    idle(6);
    rd(8'h4C, '0, 32'h100, "R6 filtered pulse no int");
    rd(8'h3C, '0, 32'h100, "R6 filtered pulse level");
    @(negedge clk); pad_in[9] = 1'b1;
    @(negedge clk); pad_in[9] = 1'b0;
    idle(6);
    rd(8'h4C, 32'h200, 32'h200, "R6 unfiltered pulse int");
    pad_in[8] = 1'b1;
    idle(6);
    rd(8'h3C, 32'h100, 32'h100, "R6 filtered steady level");

    idle(3);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: %0d reads got no data expected 0", exp_q.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule